// File: doc/BRIEF.md
# TLB Entry Invalidation Sequencer

This block walks the entries of a translation buffer one per cycle and decides, for each entry it visits, whether that entry's valid bit must be cleared. The buffer has a set-associative region (8 ways of 256 sets, entry number = way * 256 + set) and a fully associative region of 64 entries that follows it at entry numbers 2048 to 2111. The attribute storage and the valid bits live outside the block. The sequencer drives an entry number on a read port and receives that entry's ASID, virtual page-pair number, page size and global bit in the same cycle. It answers with a clear strobe for that same entry.

An operation is launched by a one-cycle start pulse that carries an operation code and its operands. These are a target index, the current ASID, an argument ASID, a global value, a virtual address and the page size used by the set-associative region. Whole-array operations sweep every entry. Line-scoped operations sweep either the eight ways of one set or the whole fully associative region. When the sweep ends, the block pulses a completion strobe together with a flush-all strobe that tells the translation caches downstream to drop their contents.

Top module: `tlbinv_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `ent_rd`, `inv_valid`, `done` and `flush_all` are all low.
- R2: A start pulse with `op_sel` 0, 1, 2, 3 or 4 visits every entry from 0 to 2111 in ascending order. It visits one entry per cycle, with `ent_rd` high during each visit. Code 0 clears every visited entry.
- R3: Code 1 clears the entries whose global bit equals `arg_g`.
- R4: Code 2 clears the entries that are not global and whose ASID equals `arg_asid`.
- R5: The page test holds when `arg_va >> (ps+1)` equals `ent_vppn >> (ps+1-13)`, where `ent_vppn` holds address bits 47..13. For entries below 2048, `ps` is `sa_ps`. For entries at 2048 and above, `ps` is the entry's own `ent_ps`. Page sizes run from 12 to 46.
- R6: Code 3 clears the entries that are not global, whose ASID equals `arg_asid` and that pass the page test.
- R7: Code 4 clears the entries that are global or whose ASID equals `arg_asid`, and that pass the page test.
- R8: For codes 5 and 6, an `op_index` below 2048 visits entries `op_index % 256 + 256*w` for w = 0 to 7, in that order. An index from 2048 to 2111 visits entries 2048 to 2111 in ascending order. An index of 2112 or more visits nothing.
- R9: Code 5 clears the visited entries that are not global and whose ASID equals `cur_asid`. Code 6 clears every visited entry.
- R10: `done` and `flush_all` are high for exactly one cycle, the cycle after the last visit. When an operation visits nothing (code 7, or a line operation with an out-of-range index), they pulse in the cycle after the start pulse.
- R11: A start pulse while `busy` is high is ignored. The running sweep keeps its order and length, and only one completion pulse follows.
- R12: `inv_valid` is high only during a visit, and `inv_idx` then equals `ent_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, taken only while idle |
| op_sel | input | 3 | Operation code (0..7) |
| op_index | input | 12 | Target index for line operations |
| cur_asid | input | 10 | Current ASID used by line clear |
| arg_asid | input | 10 | ASID operand of codes 2, 3 and 4 |
| arg_g | input | 1 | Global value compared by code 1 |
| arg_va | input | 48 | Virtual address for the page test |
| sa_ps | input | 6 | Page size of the set-associative region |
| ent_rd | output | 1 | Entry read request (a visit is in progress) |
| ent_idx | output | 12 | Entry being visited |
| ent_asid | input | 10 | ASID of the visited entry |
| ent_vppn | input | 35 | Page-pair number (address bits 47..13) of the visited entry |
| ent_ps | input | 6 | Page size of the visited entry |
| ent_g | input | 1 | Global bit of the visited entry |
| inv_valid | output | 1 | Clear the valid bit of `inv_idx` |
| inv_idx | output | 12 | Entry to clear |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion strobe |
| flush_all | output | 1 | One-cycle downstream flush strobe |

## Verification
The attribute array mixes five ASIDs and a sparse global bit. Every third entry holds a page number close to the target, differing only in its low bits. The fully associative entries take page sizes 12, 13, 14 and 21. With this mix, the page operations show whether the compare shift follows each entry's own size, and whether `sa_ps` is used in the set-associative region. Two `sa_ps` values (12 and 13) split exact-match entries from pair-match entries. The global-or-ASID form is set against the strict non-global form on the same address. The line operations are tried with a set index, a fully associative index and an out-of-range index, which exposes wrong region splits and wrong way strides.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
    typedef enum logic [2:0] {
        OP_ALL         = 3'd0,
        OP_BY_G        = 3'd1,
        OP_BY_ASID     = 3'd2,
        OP_PAGE_ASID   = 3'd3,
        OP_PAGE_ASID_G = 3'd4,
        OP_LINE_CLR    = 3'd5,
        OP_LINE_FLUSH  = 3'd6,
        OP_NONE        = 3'd7
    } inv_op_e;
endpackage

// File: rtl/tlbinv_range.sv
module tlbinv_range
    import tlbinv_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int SETS  = 256,
    parameter int FA_N  = 64,
    parameter int IDX_W = 12
) (
    input  inv_op_e          op,
    input  logic [IDX_W-1:0] index,
    output logic             any,
    output logic [IDX_W-1:0] first,
    output logic [IDX_W-1:0] last,
    output logic             by_way
);
    localparam int SA_N  = WAYS * SETS;
    localparam int TOTAL = SA_N + FA_N;
    localparam logic [IDX_W-1:0] SA_L    = IDX_W'(SA_N);
    localparam logic [IDX_W-1:0] TOTAL_L = IDX_W'(TOTAL);
    localparam logic [IDX_W-1:0] SETS_L  = IDX_W'(SETS);
    localparam logic [IDX_W-1:0] SPAN_L  = IDX_W'((WAYS - 1) * SETS);

    always_comb begin
        any    = 1'b0;
        first  = '0;
        last   = '0;
        by_way = 1'b0;
        unique case (op)
            OP_ALL, OP_BY_G, OP_BY_ASID, OP_PAGE_ASID, OP_PAGE_ASID_G: begin
                any  = 1'b1;
                last = TOTAL_L - 1'b1;
            end
            OP_LINE_CLR, OP_LINE_FLUSH: begin
                if (index < SA_L) begin
                    any    = 1'b1;
                    by_way = 1'b1;
                    first  = index % SETS_L;
                    last   = (index % SETS_L) + SPAN_L;
                end else if (index < TOTAL_L) begin
                    any   = 1'b1;
                    first = SA_L;
                    last  = TOTAL_L - 1'b1;
                end
            end
            default: any = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlbinv_match.sv
module tlbinv_match
    import tlbinv_pkg::*;
#(
    parameter int ASID_W = 10,
    parameter int VA_W   = 48,
    parameter int PG_LSB = 13,
    parameter int PS_W   = 6
) (
    input  inv_op_e                 op,
    input  logic [ASID_W-1:0]       e_asid,
    input  logic [VA_W-PG_LSB-1:0]  e_vppn,
    input  logic                    e_g,
    input  logic [PS_W-1:0]         ps,
    input  logic [ASID_W-1:0]       now_asid,
    input  logic [ASID_W-1:0]       op_asid,
    input  logic                    op_g,
    input  logic [VA_W-1:0]         va,
    output logic                    hit
);
    logic [PS_W:0]   shamt;
    logic [VA_W-1:0] keep;
    logic [VA_W-1:0] e_base;
    logic            page_eq, arg_eq, cur_eq;

    always_comb begin
        shamt   = {1'b0, ps} + 1'b1;
        keep    = ~((VA_W'(1) << shamt) - VA_W'(1));
        e_base  = {e_vppn, {PG_LSB{1'b0}}};
        page_eq = ((va ^ e_base) & keep) == '0;
        arg_eq  = (e_asid == op_asid);
        cur_eq  = (e_asid == now_asid);
        unique case (op)
            OP_ALL:         hit = 1'b1;
            OP_BY_G:        hit = (e_g == op_g);
            OP_BY_ASID:     hit = !e_g && arg_eq;
            OP_PAGE_ASID:   hit = !e_g && arg_eq && page_eq;
            OP_PAGE_ASID_G: hit = (e_g || arg_eq) && page_eq;
            OP_LINE_CLR:    hit = !e_g && cur_eq;
            OP_LINE_FLUSH:  hit = 1'b1;
            default:        hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlbinv_seq.sv
module tlbinv_seq
    import tlbinv_pkg::*;
#(
    parameter int WAYS   = 8,
    parameter int SETS   = 256,
    parameter int FA_N   = 64,
    parameter int ASID_W = 10,
    parameter int VA_W   = 48,
    parameter int PG_LSB = 13,
    parameter int PS_W   = 6,
    localparam int SA_N  = WAYS * SETS,
    localparam int TOTAL = SA_N + FA_N,
    localparam int IDX_W = $clog2(TOTAL),
    localparam int VPN_W = VA_W - PG_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op_sel,
    input  logic [IDX_W-1:0]  op_index,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [ASID_W-1:0] arg_asid,
    input  logic              arg_g,
    input  logic [VA_W-1:0]   arg_va,
    input  logic [PS_W-1:0]   sa_ps,
    output logic              ent_rd,
    output logic [IDX_W-1:0]  ent_idx,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic [VPN_W-1:0]  ent_vppn,
    input  logic [PS_W-1:0]   ent_ps,
    input  logic              ent_g,
    output logic              inv_valid,
    output logic [IDX_W-1:0]  inv_idx,
    output logic              busy,
    output logic              done,
    output logic              flush_all
);
    localparam logic [IDX_W-1:0] SA_L   = IDX_W'(SA_N);
    localparam logic [IDX_W-1:0] SETS_L = IDX_W'(SETS);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              by_way;
        inv_op_e           op;
        logic [IDX_W-1:0]  cur;
        logic [IDX_W-1:0]  last;
        logic [ASID_W-1:0] now_asid;
        logic [ASID_W-1:0] op_asid;
        logic              op_g;
        logic [VA_W-1:0]   va;
        logic [PS_W-1:0]   sps;
    } seq_t;

    seq_t st_d, st_q;

    logic             rng_any, rng_way;
    logic [IDX_W-1:0] rng_first, rng_last;
    logic [PS_W-1:0]  ps_sel;
    logic             hit;

    tlbinv_range #(
        .WAYS(WAYS), .SETS(SETS), .FA_N(FA_N), .IDX_W(IDX_W)
    ) u_range (
        .op(inv_op_e'(op_sel)),
        .index(op_index),
        .any(rng_any),
        .first(rng_first),
        .last(rng_last),
        .by_way(rng_way)
    );

    assign ps_sel = (st_q.cur < SA_L) ? st_q.sps : ent_ps;

    tlbinv_match #(
        .ASID_W(ASID_W), .VA_W(VA_W), .PG_LSB(PG_LSB), .PS_W(PS_W)
    ) u_match (
        .op(st_q.op),
        .e_asid(ent_asid),
        .e_vppn(ent_vppn),
        .e_g(ent_g),
        .ps(ps_sel),
        .now_asid(st_q.now_asid),
        .op_asid(st_q.op_asid),
        .op_g(st_q.op_g),
        .va(st_q.va),
        .hit(hit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cur == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cur = st_q.cur + (st_q.by_way ? SETS_L : IDX_W'(1));
            end
        end else if (start) begin
            st_d.op       = inv_op_e'(op_sel);
            st_d.now_asid = cur_asid;
            st_d.op_asid  = arg_asid;
            st_d.op_g     = arg_g;
            st_d.va       = arg_va;
            st_d.sps      = sa_ps;
            st_d.cur      = rng_first;
            st_d.last     = rng_last;
            st_d.by_way   = rng_way;
            st_d.busy     = rng_any;
            st_d.done     = !rng_any;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ent_rd    = st_q.busy;
    assign ent_idx   = st_q.cur;
    assign inv_valid = st_q.busy && hit;
    assign inv_idx   = st_q.cur;
    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign flush_all = st_q.done;
endmodule

// File: rtl/tlbinv_chk.sv
module tlbinv_chk #(
    parameter int IDX_W = 12,
    parameter int TOTAL = 2112
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ent_rd,
    input logic [IDX_W-1:0] ent_idx,
    input logic             inv_valid,
    input logic             done
);
    AST_INV_NEEDS_VISIT: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> ent_rd); // R12
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ent_rd |-> (int'(ent_idx) < TOTAL)); // R8
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_rd && $past(ent_rd)) |-> (ent_idx > $past(ent_idx))); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ent_rd) |-> done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ent_rd); // R10
endmodule

bind tlbinv_seq tlbinv_chk #(.IDX_W(IDX_W), .TOTAL(TOTAL)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .ent_rd(ent_rd),
    .ent_idx(ent_idx),
    .inv_valid(inv_valid),
    .done(done)
);

// File: tb/sim_tlbinv_seq.sv
`timescale 1ns/1ps
module sim_tlbinv_seq;
    localparam int SA    = 2048;
    localparam int TOTAL = 2112;
    localparam logic [34:0] TGT = 35'h2_3456_7891;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [11:0] op_index = '0;
    logic [9:0]  cur_asid = '0;
    logic [9:0]  arg_asid = '0;
    logic        arg_g = 1'b0;
    logic [47:0] arg_va = '0;
    logic [5:0]  sa_ps = 6'd12;
    logic        ent_rd, inv_valid, busy, done, flush_all;
    logic [11:0] ent_idx, inv_idx;
    logic [9:0]  ent_asid;
    logic [34:0] ent_vppn;
    logic [5:0]  ent_ps;
    logic        ent_g;

    logic [9:0]  m_asid [TOTAL];
    logic [34:0] m_vppn [TOTAL];
    logic [5:0]  m_ps   [TOTAL];
    logic        m_g    [TOTAL];

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign ent_asid = m_asid[ent_idx];
    assign ent_vppn = m_vppn[ent_idx];
    assign ent_ps   = m_ps[ent_idx];
    assign ent_g    = m_g[ent_idx];

    tlbinv_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .op_index(op_index), .cur_asid(cur_asid), .arg_asid(arg_asid),
        .arg_g(arg_g), .arg_va(arg_va), .sa_ps(sa_ps),
        .ent_rd(ent_rd), .ent_idx(ent_idx), .ent_asid(ent_asid),
        .ent_vppn(ent_vppn), .ent_ps(ent_ps), .ent_g(ent_g),
        .inv_valid(inv_valid), .inv_idx(inv_idx), .busy(busy),
        .done(done), .flush_all(flush_all)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_hit(input int op, input int i);
        int ps;
        longint unsigned vpn, ev;
        bit pg, ae, ce;
        ps  = (i < SA) ? int'(sa_ps) : int'(m_ps[i]);
        vpn = 64'(arg_va) >> (ps + 1);
        ev  = 64'(m_vppn[i]) >> (ps + 1 - 13);
        pg  = (vpn == ev);
        ae  = (m_asid[i] == arg_asid);
        ce  = (m_asid[i] == cur_asid);
        case (op)
            0: return 1'b1;
            1: return m_g[i] == arg_g;
            2: return !m_g[i] && ae;
            3: return !m_g[i] && ae && pg;
            4: return (m_g[i] || ae) && pg;
            5: return !m_g[i] && ce;
            6: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run_op(input int op, input int idx, input string req, input bit disturb);
        int first, stride, n, k, bad_idx, bad_hit, bad_tag;
        first = 0; stride = 1; n = 0;
        if (op <= 4) begin
            n = TOTAL;
        end else if (op <= 6) begin
            if (idx < SA) begin
                first = idx % 256; stride = 256; n = 8;
            end else if (idx < TOTAL) begin
                first = SA; n = TOTAL - SA;
            end
        end
        @(negedge clk);
        op_sel = 3'(op); op_index = 12'(idx); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0; bad_idx = 0; bad_hit = 0; bad_tag = 0;
        while (ent_rd && k < TOTAL + 4) begin
            if (int'(ent_idx) != first + k * stride) bad_idx++;
            else if (inv_valid != exp_hit(op, int'(ent_idx))) bad_hit++;
            if (inv_valid && inv_idx != ent_idx) bad_tag++;
            if (disturb && k == 5) begin
                start = 1'b1; op_sel = 3'd6; op_index = 12'd5;
            end
            if (disturb && k == 6) begin
                start = 1'b0; op_sel = 3'(op);
            end
            k++;
            @(negedge clk);
        end
        chk(k == n, {req, " visit count"}, k, n);
        chk(bad_idx == 0, {req, " visit order"}, bad_idx, 0);
        chk(bad_hit == 0, {req, " clear decision"}, bad_hit, 0);
        chk(bad_tag == 0, "R12 inv_idx tracks ent_idx", bad_tag, 0);
        chk(done && flush_all, "R10 completion pulse", {done, flush_all}, 3);
        @(negedge clk);
        chk(!done && !flush_all && !busy, "R10 single pulse", {done, flush_all, busy}, 0);
    endtask

    task automatic t_reset;
        chk(!busy && !ent_rd && !inv_valid && !done && !flush_all, "R1 reset state",
            {busy, ent_rd, inv_valid, done, flush_all}, 0);
    endtask

    task automatic t_all_r2_r11;
        run_op(0, 0, "R2 R11 invalidate all with ignored restart", 1'b1);
    endtask

    task automatic t_by_g_r3;
        arg_g = 1'b1; run_op(1, 0, "R3 global=1", 1'b0);
        arg_g = 1'b0; run_op(1, 0, "R3 global=0", 1'b0);
    endtask

    task automatic t_by_asid_r4;
        arg_asid = 10'd4; run_op(2, 0, "R4 by asid", 1'b0);
    endtask

    task automatic t_page_r5_r6_r7;
        arg_va = {TGT, 13'h1abc};
        sa_ps = 6'd12; arg_asid = 10'd3; run_op(3, 0, "R5 R6 page+asid ps12", 1'b0);
        sa_ps = 6'd13; arg_asid = 10'd5; run_op(3, 0, "R5 R6 page+asid ps13", 1'b0);
        sa_ps = 6'd12; arg_asid = 10'd6; run_op(4, 0, "R5 R7 page+asid|g ps12", 1'b0);
        sa_ps = 6'd13; arg_asid = 10'd7; run_op(4, 0, "R5 R7 page+asid|g ps13", 1'b0);
    endtask

    task automatic t_line_r8_r9;
        cur_asid = 10'd4;
        run_op(5, 1000, "R8 R9 line clear set", 1'b0);
        run_op(5, 2050, "R8 R9 line clear assoc", 1'b0);
        run_op(6, 300, "R8 R9 line flush set", 1'b0);
        run_op(6, 2111, "R8 R9 line flush assoc", 1'b0);
    endtask

    task automatic t_empty_r8_r10;
        run_op(6, 3000, "R8 R10 out-of-range line", 1'b0);
        run_op(7, 0, "R10 empty operation", 1'b0);
    endtask

    initial begin
        for (int i = 0; i < TOTAL; i++) begin
            m_asid[i] = 10'(i % 5) + 10'd3;
            m_g[i]    = (i % 7 == 0);
            if (i < SA) m_ps[i] = 6'd40;
            else begin
                case (i % 4)
                    0: m_ps[i] = 6'd12;
                    1: m_ps[i] = 6'd13;
                    2: m_ps[i] = 6'd14;
                    default: m_ps[i] = 6'd21;
                endcase
            end
            if (i % 3 == 0) m_vppn[i] = TGT ^ 35'(i % 8);
            else            m_vppn[i] = 35'(i * 977);
        end
        #1;
        t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_all_r2_r11;
        t_by_g_r3;
        t_by_asid_r4;
        t_page_r5_r6_r7;
        t_line_r8_r9;
        t_empty_r8_r10;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1900000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule